// File: doc/BRIEF.md
# Microstep Sine Sequencer

This block is the position indexer of a two-winding stepper drive. It turns step and direction pulses into signed current-level codes for winding A and winding B, expressed as whole percentages of full current. Each level traces one electrical cycle of a cosine (A) and sine (B) pair. A 3-bit mode selector picks the step resolution: full, two half-step variants, quarter, eighth or sixteenth. Two of the eight codes put the sequencer to sleep. The block sits ahead of the current regulator, which consumes the two level codes.

Internally one 6-bit position spans 64 points per electrical cycle. A coarser mode moves that position by a larger stride. A home input held low parks the sequencer at its initial position. So does any change of the mode code. A monitor flag reports when the sequencer sits at that initial position. After sleep ends, the block ignores step edges for a programmable settling window. The controller is a four-state machine:

- `S_SLEEP`: both levels are zero and the monitor is released.
- `S_SETTLE`: the settling window; the position is held at its initial value.
- `S_HOLD_HOME`: home is held low.
- `S_RUN`: steps are accepted.

The transitions are:

- **sleep-entry**: any state moves to `S_SLEEP` when a sleep code appears. This has the highest priority.
- **wake**: `S_SLEEP` moves to `S_SETTLE` on a non-sleep code.
- **settle-done**: `S_SETTLE` leaves after `HOLD_CYCLES` cycles. It goes to `S_RUN` if home is high, or to `S_HOLD_HOME` if home is low.
- **home-grab**: `S_RUN` moves to `S_HOLD_HOME` when home goes low.
- **home-release**: `S_HOLD_HOME` moves to `S_RUN` when home goes high.

Top module: `msq_indexer`

## Requirements
- R1: `mode_i` is decoded as follows. 3'b000 and 3'b111 mean sleep. 3'b001 is full step, 3'b010 is half step with levels 0/71/100, 3'b011 is half step with levels 0/100, 3'b100 is quarter, 3'b101 is eighth and 3'b110 is sixteenth. One cycle after a sleep code is sampled, both levels read 0 and `home_pull_o` is 0. The same holds while `rst_ni` is low.
- R2: Each rising edge of `step_i` moves the position p (0..63, wrapping) by the stride. The stride is 1 for sixteenth, 2 for eighth, 4 for quarter, 8 for either half step and 16 for full step. `dir_i` low adds the stride and high subtracts it. With SYNC_STAGES=2, a step rising before clock edge n shows on the outputs after edge n+2 and not after edge n+1.
- R3: `lvl_a_o` equals round(100·cos(2πp/64)) and `lvl_b_o` equals round(100·sin(2πp/64)), as 8-bit two's complement values, rounded half away from zero. The magnitude never exceeds 100.
- R4: While `home_ni` is low outside sleep, the position returns to its initial value one cycle later and step edges are ignored. After home is released, the next step advances from the initial value.
- R5: A change of `mode_i` to a non-sleep code restarts the sequencer at the new mode's initial position one cycle later. This overrides a step edge detected in the same cycle.
- R6: The initial position is p=0 (A=100, B=0) in every mode except full step. In full step it is p=56 (A=100, B=-100).
- R7: In full step and in the 0/100 half step, a magnitude of 71 is output as 100. In full step both levels therefore always have magnitude 100.
- R8: `home_pull_o` is 1 (monitor driven low) exactly when the sequencer is outside sleep and at the initial position of the current mode.
- R9: After leaving sleep, step edges are ignored for HOLD_CYCLES cycles. The position stays initial and no ignored edge is applied late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| step_i | input | 1 | Step pulse; rising edge advances the position |
| dir_i | input | 1 | Direction: 0 adds the stride, 1 subtracts it |
| home_ni | input | 1 | Home request, active low; parks at the initial position |
| mode_i | input | 3 | Resolution and sleep selector |
| lvl_a_o | output | LVL_W | Signed percent level for winding A |
| lvl_b_o | output | LVL_W | Signed percent level for winding B |
| home_pull_o | output | 1 | 1 = monitor line pulled low (initial position) |

## Verification
A synchronized step edge and a mode change can land in the same cycle. Restart must then win, and the edge must not surface a cycle later. The bench raises `step_i` and switches `mode_i` exactly two falling edges later. That places the mode difference in the cycle where the synchronized edge is detected. It then expects the initial position, followed by a single one-stride advance on the next step. Home-low against a step pulse, and a step pulse inside the settling window, are provoked and judged the same way.

// File: rtl/msq_pkg.sv
package msq_pkg;

    localparam int POS_W = 6;
    localparam int QTR_W = POS_W - 2;

    typedef enum logic [1:0] {
        S_SLEEP,
        S_SETTLE,
        S_HOLD_HOME,
        S_RUN
    } seq_state_e;

    typedef enum logic [2:0] {
        MD_SLEEP_LO   = 3'b000,
        MD_FULL       = 3'b001,
        MD_HALF_FINE  = 3'b010,
        MD_HALF_BOOST = 3'b011,
        MD_QUARTER    = 3'b100,
        MD_EIGHTH     = 3'b101,
        MD_SIXTEENTH  = 3'b110,
        MD_SLEEP_HI   = 3'b111
    } mode_e;

    typedef struct packed {
        logic             sleep;
        logic             boost;
        logic [POS_W-1:0] stride;
        logic [POS_W-1:0] home_pos;
    } mode_cfg_t;

endpackage

// File: rtl/msq_sync.sv
module msq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[g] <= 1'b0;
                else         chain_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[g] <= 1'b0;
                else         chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/msq_mode_decode.sv
module msq_mode_decode
    import msq_pkg::*;
(
    input  logic [2:0] code_i,
    output mode_cfg_t  cfg_o
);
    localparam logic [POS_W-1:0] STR_16 = POS_W'(1);
    localparam logic [POS_W-1:0] STR_8  = POS_W'(2);
    localparam logic [POS_W-1:0] STR_4  = POS_W'(4);
    localparam logic [POS_W-1:0] STR_2  = POS_W'(1 << (POS_W - 3));
    localparam logic [POS_W-1:0] STR_1  = POS_W'(1 << (POS_W - 2));
    localparam logic [POS_W-1:0] FULL_HOME = POS_W'((1 << POS_W) - (1 << (POS_W - 3)));

    always_comb begin
        cfg_o = '{sleep: 1'b0, boost: 1'b0, stride: STR_16, home_pos: '0};
        unique case (mode_e'(code_i))
            MD_SLEEP_LO, MD_SLEEP_HI: cfg_o.sleep = 1'b1;
            MD_FULL: begin
                cfg_o.stride   = STR_1;
                cfg_o.boost    = 1'b1;
                cfg_o.home_pos = FULL_HOME;
            end
            MD_HALF_FINE:  cfg_o.stride = STR_2;
            MD_HALF_BOOST: begin
                cfg_o.stride = STR_2;
                cfg_o.boost  = 1'b1;
            end
            MD_QUARTER:    cfg_o.stride = STR_4;
            MD_EIGHTH:     cfg_o.stride = STR_8;
            MD_SIXTEENTH:  cfg_o.stride = STR_16;
            default:       cfg_o.sleep  = 1'b1;
        endcase
    end
endmodule

// File: rtl/msq_level_lut.sv
module msq_level_lut
    import msq_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic [POS_W-1:0]        pos_i,
    input  logic                    boost_i,
    output logic signed [LVL_W-1:0] level_o
);
    localparam logic [QTR_W:0] K_PEAK = (QTR_W+1)'(1 << QTR_W);
    localparam logic [QTR_W:0] K_MID  = (QTR_W+1)'(1 << (QTR_W - 1));

    logic [1:0]       quad;
    logic [QTR_W-1:0] off;
    logic [QTR_W:0]   k;
    logic [7:0]       mag8;
    logic [LVL_W-1:0] mag;

    function automatic logic [7:0] sine_mag(input logic [QTR_W:0] idx);
        logic [7:0] m;
        case (idx)
            5'd0:  m = 8'd0;
            5'd1:  m = 8'd10;
            5'd2:  m = 8'd20;
            5'd3:  m = 8'd29;
            5'd4:  m = 8'd38;
            5'd5:  m = 8'd47;
            5'd6:  m = 8'd56;
            5'd7:  m = 8'd63;
            5'd8:  m = 8'd71;
            5'd9:  m = 8'd77;
            5'd10: m = 8'd83;
            5'd11: m = 8'd88;
            5'd12: m = 8'd92;
            5'd13: m = 8'd96;
            5'd14: m = 8'd98;
            5'd15: m = 8'd100;
            5'd16: m = 8'd100;
            default: m = 8'd0;
        endcase
        return m;
    endfunction

    always_comb begin
        quad = pos_i[POS_W-1 -: 2];
        off  = pos_i[QTR_W-1:0];
        k    = quad[0] ? (K_PEAK - {1'b0, off}) : {1'b0, off};
        mag8 = (boost_i && k == K_MID) ? 8'd100 : sine_mag(k);
        mag  = LVL_W'(mag8);
        level_o = quad[1] ? $signed(LVL_W'(0) - mag) : $signed(mag);
    end
endmodule

// File: rtl/msq_indexer.sv
module msq_indexer #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 10000,
    parameter int LVL_W       = 8
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    step_i,
    input  logic                    dir_i,
    input  logic                    home_ni,
    input  logic [2:0]              mode_i,
    output logic signed [LVL_W-1:0] lvl_a_o,
    output logic signed [LVL_W-1:0] lvl_b_o,
    output logic                    home_pull_o
);
    import msq_pkg::*;

    localparam int               CNT_W     = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);
    localparam int               N_PHASE   = 2;

    // synchronized step / direction and edge detection
    logic step_s, dir_s, step_d, step_rise;

    msq_sync #(.STAGES(SYNC_STAGES)) u_sync_step (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(step_i), .q_o(step_s));
    msq_sync #(.STAGES(SYNC_STAGES)) u_sync_dir (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dir_i), .q_o(dir_s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) step_d <= 1'b0;
        else         step_d <= step_s;
    end
    assign step_rise = step_s & ~step_d;

    // mode decode: live code and the code in force
    logic [2:0] mode_q;
    mode_cfg_t  cfg_in, cfg_q;
    logic       mode_chg;

    msq_mode_decode u_dec_in  (.code_i(mode_i), .cfg_o(cfg_in));
    msq_mode_decode u_dec_cur (.code_i(mode_q), .cfg_o(cfg_q));
    assign mode_chg = (mode_i != mode_q);

    // controller state
    seq_state_e       st_q, st_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        cnt_d = cnt_q;
        if (cfg_in.sleep) begin
            st_d  = S_SLEEP;
            pos_d = '0;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                S_SLEEP: begin
                    st_d  = S_SETTLE;
                    cnt_d = '0;
                    pos_d = cfg_in.home_pos;
                end
                S_SETTLE: begin
                    pos_d = cfg_in.home_pos;
                    if (cnt_q == HOLD_LAST) begin
                        st_d = home_ni ? S_RUN : S_HOLD_HOME;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                S_HOLD_HOME: begin
                    pos_d = cfg_in.home_pos;
                    if (home_ni) st_d = S_RUN;
                end
                S_RUN: begin
                    if (!home_ni) begin
                        st_d  = S_HOLD_HOME;
                        pos_d = cfg_in.home_pos;
                    end else if (mode_chg) begin
                        pos_d = cfg_in.home_pos;
                    end else if (step_rise) begin
                        pos_d = dir_s ? (pos_q - cfg_q.stride) : (pos_q + cfg_q.stride);
                    end
                end
                default: st_d = S_SLEEP;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q   <= S_SLEEP;
            pos_q  <= '0;
            cnt_q  <= '0;
            mode_q <= 3'b000;
        end else begin
            st_q   <= st_d;
            pos_q  <= pos_d;
            cnt_q  <= cnt_d;
            mode_q <= mode_i;
        end
    end

    // two phases: A leads B by a quarter cycle
    logic signed [LVL_W-1:0] phase_lvl [N_PHASE];

    for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
        localparam logic [POS_W-1:0] SHIFT = (g == 0) ? POS_W'(1 << QTR_W) : '0;
        msq_level_lut #(.LVL_W(LVL_W)) u_lut (
            .pos_i  (pos_q + SHIFT),
            .boost_i(cfg_q.boost),
            .level_o(phase_lvl[g])
        );
    end

    always_comb begin
        if (st_q == S_SLEEP) begin
            lvl_a_o     = '0;
            lvl_b_o     = '0;
            home_pull_o = 1'b0;
        end else begin
            lvl_a_o     = phase_lvl[0];
            lvl_b_o     = phase_lvl[1];
            home_pull_o = (pos_q == cfg_q.home_pos);
        end
    end
endmodule

// File: rtl/msq_checker.sv
module msq_checker #(
    parameter int LVL_W = 8
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    home_ni,
    input logic [2:0]              mode_i,
    input logic signed [LVL_W-1:0] lvl_a_o,
    input logic signed [LVL_W-1:0] lvl_b_o,
    input logic                    home_pull_o
);
    function automatic logic is_sleep(input logic [2:0] m);
        return (m == 3'b000) || (m == 3'b111);
    endfunction

    AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_sleep(mode_i) |=> (lvl_a_o == 0 && lvl_b_o == 0 && !home_pull_o)); // R1

    AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_a_o <= 100 && lvl_a_o >= -100 && lvl_b_o <= 100 && lvl_b_o >= -100)); // R3

    AST_HOME_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!home_ni && !is_sleep(mode_i)) |=> home_pull_o); // R4

    AST_MODE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i != $past(mode_i) && !is_sleep(mode_i)) |=> home_pull_o); // R5

    AST_FULL_MAGNITUDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 3'b001 && $past(mode_i) == 3'b001) |=>
        ((lvl_a_o == 100 || lvl_a_o == -100) && (lvl_b_o == 100 || lvl_b_o == -100))); // R7
endmodule

bind msq_indexer msq_checker #(.LVL_W(LVL_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .home_ni    (home_ni),
    .mode_i     (mode_i),
    .lvl_a_o    (lvl_a_o),
    .lvl_b_o    (lvl_b_o),
    .home_pull_o(home_pull_o)
);

// File: tb/sim_msq_indexer.sv
module sim_msq_indexer;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step = 1'b0;
    logic dir = 1'b0;
    logic home_n = 1'b1;
    logic [2:0] mode = 3'b000;
    logic signed [7:0] lvl_a, lvl_b;
    logic home_pull;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msq_indexer #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .LVL_W(8)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .step_i(step), .dir_i(dir),
        .home_ni(home_n), .mode_i(mode),
        .lvl_a_o(lvl_a), .lvl_b_o(lvl_b), .home_pull_o(home_pull));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string what);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int exp_level(input int p, input bit cosine, input bit boost);
        real ang, v;
        int r;
        ang = 2.0 * 3.14159265358979 * real'(p + (cosine ? 16 : 0)) / 64.0;
        v = 100.0 * $sin(ang);
        r = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
        if (boost && (r == 71 || r == -71)) r = (r > 0) ? 100 : -100;
        return r;
    endfunction

    function automatic int stride_of(input logic [2:0] m);
        case (m)
            3'b001:         return 16;
            3'b010, 3'b011: return 8;
            3'b100:         return 4;
            3'b101:         return 2;
            default:        return 1;
        endcase
    endfunction

    function automatic int home_of(input logic [2:0] m);
        return (m == 3'b001) ? 56 : 0;
    endfunction

    task automatic chk_pos(input int p, input logic [2:0] m, input string tag);
        bit bst;
        bst = (m == 3'b001 || m == 3'b011);
        chk(int'(lvl_a), exp_level(p, 1'b1, bst), {tag, " phase A"});
        chk(int'(lvl_b), exp_level(p, 1'b0, bst), {tag, " phase B"});
        chk(int'(home_pull), (p == home_of(m)) ? 1 : 0, {tag, " monitor"});
    endtask

    task automatic do_step;
        step = 1'b1;
        tick(4);
        step = 1'b0;
        tick(4);
    endtask

    task automatic wake(input logic [2:0] m);
        mode = 3'b000;
        tick(3);
        mode = m;
        tick(HOLD + 4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [2:0] modes [6];
        int p;
        modes = '{3'b001, 3'b010, 3'b011, 3'b100, 3'b101, 3'b110};
        mode = 3'b100;
        tick(3);
        // R1: quiet while system reset is held
        chk(int'(lvl_a), 0, "R1 reset level A");
        chk(int'(lvl_b), 0, "R1 reset level B");
        chk(int'(home_pull), 0, "R1 reset monitor");
        rst_n = 1'b1;
        mode = 3'b111;
        tick(3);
        chk(int'(lvl_a), 0, "R1 sleep 111 level A");
        chk(int'(home_pull), 0, "R1 sleep 111 monitor");

        // R2 R3 R6 R7 R8: sweep every mode in both directions
        foreach (modes[i]) begin
            for (int d = 0; d < 2; d++) begin
                wake(modes[i]);
                dir = d[0];
                tick(3);
                p = home_of(modes[i]);
                chk_pos(p, modes[i], "R6,R8 initial");
                for (int s = 0; s < 64 / stride_of(modes[i]) + 2; s++) begin
                    do_step();
                    p = d ? (p - stride_of(modes[i]) + 64) % 64 : (p + stride_of(modes[i])) % 64;
                    chk_pos(p, modes[i], "R2,R3,R7,R8 sweep");
                end
            end
        end
        dir = 1'b0;

        // R2: latency through the synchronizer
        wake(3'b110);
        step = 1'b1;
        tick(2);
        chk(int'(lvl_b), 0, "R2 not yet advanced");
        tick(1);
        chk(int'(lvl_b), exp_level(1, 1'b0, 1'b0), "R2 advanced");
        step = 1'b0;
        tick(4);

        // R9: step inside the settling window is dropped
        mode = 3'b000;
        tick(3);
        mode = 3'b110;
        tick(2);
        do_step();
        chk(int'(lvl_b), 0, "R9 step during settle");
        chk(int'(home_pull), 1, "R9 monitor during settle");
        tick(HOLD);
        chk(int'(lvl_b), 0, "R9 no late step");
        do_step();
        chk_pos(1, 3'b110, "R9 first step after settle");

        // R4: home parks and blocks steps
        do_step();
        home_n = 1'b0;
        tick(3);
        chk_pos(0, 3'b110, "R4 home parks");
        do_step();
        chk_pos(0, 3'b110, "R4 step ignored while home");
        home_n = 1'b1;
        tick(2);
        do_step();
        chk_pos(1, 3'b110, "R4 resume from initial");

        // R5: mode change restarts
        mode = 3'b100;
        tick(3);
        do_step();
        do_step();
        chk_pos(8, 3'b100, "R5 before change");
        mode = 3'b101;
        tick(3);
        chk_pos(0, 3'b101, "R5 restart on change");
        do_step();
        // R5: step edge and mode change in the same cycle
        step = 1'b1;
        tick(2);
        mode = 3'b110;
        tick(2);
        step = 1'b0;
        tick(4);
        chk_pos(0, 3'b110, "R5 change beats step");
        do_step();
        chk_pos(1, 3'b110, "R5 single step after tie");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule